// File: doc/BRIEF.md
# Isochronous Cycle and Fairness Controller

This block keeps bus-cycle timing for a serial bus node and controls how the node takes part in asynchronous arbitration. When the node is the root, it acts as cycle master. A free-running tick counter then raises a cycle-start request once per nominal cycle period, which is 125 µs at the default clock. If the bus is busy when the tick falls due, the request waits until the bus has been idle for one subaction gap. The number of clocks the start had to wait is reported next to the start pulse.

The same idle-run counter sorts bus gaps by length. A short run marks a subaction gap. A longer run marks an arbitration reset gap, which closes one fairness interval. An enable flag allows the node at most one asynchronous arbitration win per interval. The flag is set at each arbitration reset gap and cleared when the node wins. Isochronous requests pass straight through whatever the flag holds.

A watchdog counts the clocks of isochronous activity seen since the last cycle start. If that count reaches the limit (100 µs by default), the watchdog raises a sticky over-allocation flag, and no further cycle starts are issued. A bus reset clears the flag and also re-opens arbitration. All time limits are parameters in clock ticks, so a shortened clock scale can be used in simulation.

Top module: `iso_cycle_ctrl`

## Requirements
- R1: While rst_ni is low, cycle_start_o, subact_gap_o, arb_rst_gap_o and over_alloc_o are 0, start_delay_o is 0 and arb_enable_o is 1.
- R2: While is_root_i is high, a tick falls due every CYCLE_TICKS clocks. The tick counter starts at zero after reset and whenever is_root_i is low. While is_root_i is low, no request is held and no cycle start is issued.
- R3: A falling-due tick makes a cycle start pending. The start is issued at the first clock edge where it is pending, is_root_i is high, at least SUBACT_GAP consecutive idle samples have been taken and over_alloc_o is low. cycle_start_o is high for exactly the clock after that edge. A tick arriving while a start is already pending, or at the issuing edge, is merged into that start.
- R4: start_delay_o is loaded when a start is issued, with the number of edges the start waited after the edge that made it pending (0 when it goes out at the very next edge), saturating at 2^DELAY_W-1. It holds otherwise.
- R5: subact_gap_o is high for one clock after the SUBACT_GAP-th consecutive idle sample of bus_idle_i.
- R6: arb_rst_gap_o is high for one clock after the ARB_RST_GAP-th consecutive idle sample. Any busy sample restarts the idle count from zero.
- R7: arb_enable_o is cleared at an edge where arb_won_i is high. Otherwise it is set at an edge where arb_rst_gap_o is high.
- R8: arb_req_o equals iso_req_i OR (async_req_i AND arb_enable_o), combinationally.
- R9: Samples with iso_active_i high are counted since the last issued start, and the count is cleared at each issuing edge. The ISO_LIMIT-th such sample sets over_alloc_o. over_alloc_o then stays set until a bus reset, and no start is issued while it is set.
- R10: An edge with bus_reset_i high clears over_alloc_o and sets arb_enable_o. This takes priority over arb_won_i and over the over-allocation count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_reset_i | input | 1 | Bus reset seen, one clock |
| bus_idle_i | input | 1 | Bus idle this clock |
| is_root_i | input | 1 | Node is root and cycle master |
| iso_active_i | input | 1 | Isochronous data on the bus this clock |
| iso_req_i | input | 1 | Local isochronous arbitration request |
| async_req_i | input | 1 | Local asynchronous arbitration request |
| arb_won_i | input | 1 | Node won asynchronous arbitration, one clock |
| cycle_start_o | output | 1 | Send a cycle start, one clock pulse |
| start_delay_o | output | DELAY_W | Clocks the last start waited |
| subact_gap_o | output | 1 | Subaction gap detected, one clock pulse |
| arb_rst_gap_o | output | 1 | Arbitration reset gap detected, one clock pulse |
| arb_enable_o | output | 1 | Asynchronous arbitration allowed |
| arb_req_o | output | 1 | Arbitration request toward the physical layer |
| over_alloc_o | output | 1 | Isochronous over-allocation, sticky |

## Verification
The properties take for granted that SUBACT_GAP is smaller than ARB_RST_GAP and that CYCLE_TICKS is above one. They also assume every input is known and synchronous to clk_i from the release of reset onward. The stimulus changes inputs only on the falling edge. It builds bus activity from random idle and busy runs whose lengths straddle both gap thresholds. Bus resets and wins are kept to single-clock pulses, and stretches of non-root operation are short and separated from each other. Directed phases cover several other cases:
- a long busy stretch that merges two ticks;
- an isochronous overrun that suppresses starts until a bus reset;
- a win landing on the edge that sets the enable flag;
- a bus reset that coincides with a win.

// File: rtl/iso_cycle_pkg.sv
package iso_cycle_pkg;
  typedef struct packed {
    logic sub_gap;   // subaction gap pulse
    logic rst_gap;   // arbitration reset gap pulse
    logic gap_ok;    // idle run already long enough for a start
  } gap_info_t;

  function automatic int cnt_width(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/icc_gap_classifier.sv
module icc_gap_classifier
  import iso_cycle_pkg::*;
#(
  parameter int SUBACT_GAP  = 49,
  parameter int ARB_RST_GAP = 98
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      bus_idle_i,
  output gap_info_t gap_o
);
  localparam int W = cnt_width(ARB_RST_GAP);
  localparam logic [W-1:0] SUB_N  = W'(SUBACT_GAP);
  localparam logic [W-1:0] SUB_M1 = W'(SUBACT_GAP - 1);
  localparam logic [W-1:0] RST_N  = W'(ARB_RST_GAP);
  localparam logic [W-1:0] RST_M1 = W'(ARB_RST_GAP - 1);

  logic [W-1:0] idle_cnt_q;
  logic         sub_q, rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_cnt_q <= '0;
      sub_q      <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      if (!bus_idle_i)             idle_cnt_q <= '0;
      else if (idle_cnt_q != RST_N) idle_cnt_q <= idle_cnt_q + 1'b1;
      sub_q <= bus_idle_i && (idle_cnt_q == SUB_M1);
      rst_q <= bus_idle_i && (idle_cnt_q == RST_M1);
    end
  end

  always_comb begin
    gap_o.sub_gap = sub_q;
    gap_o.rst_gap = rst_q;
    gap_o.gap_ok  = (idle_cnt_q >= SUB_N);
  end
endmodule

// File: rtl/icc_cycle_timer.sv
module icc_cycle_timer #(
  parameter int CYCLE_TICKS = 6144,
  parameter int DELAY_W     = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               is_root_i,
  input  logic               gap_ok_i,
  input  logic               inhibit_i,
  output logic               fire_o,
  output logic               cycle_start_o,
  output logic [DELAY_W-1:0] start_delay_o
);
  localparam int CW = iso_cycle_pkg::cnt_width(CYCLE_TICKS);
  localparam logic [CW-1:0]      LAST  = CW'(CYCLE_TICKS - 1);
  localparam logic [DELAY_W-1:0] D_MAX = '1;

  logic [CW-1:0]      cyc_q;
  logic               pend_q, cs_q;
  logic [DELAY_W-1:0] dly_q, sd_q;
  logic               tick;

  assign tick   = is_root_i && (cyc_q == LAST);
  assign fire_o = pend_q && is_root_i && gap_ok_i && !inhibit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= '0;
      pend_q <= 1'b0;
      dly_q  <= '0;
      sd_q   <= '0;
      cs_q   <= 1'b0;
    end else begin
      if (!is_root_i || tick) cyc_q <= '0;
      else                    cyc_q <= cyc_q + 1'b1;

      // a tick at the issuing edge is merged into that start
      if (!is_root_i || fire_o) pend_q <= 1'b0;
      else if (tick)            pend_q <= 1'b1;

      if (tick && !pend_q)              dly_q <= '0;
      else if (pend_q && dly_q != D_MAX) dly_q <= dly_q + 1'b1;

      cs_q <= fire_o;
      if (fire_o) sd_q <= dly_q;
    end
  end

  assign cycle_start_o = cs_q;
  assign start_delay_o = sd_q;
endmodule

// File: rtl/icc_iso_watchdog.sv
module icc_iso_watchdog #(
  parameter int ISO_LIMIT = 4915
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_reset_i,
  input  logic iso_active_i,
  input  logic fire_i,
  output logic over_alloc_o
);
  localparam int W = iso_cycle_pkg::cnt_width(ISO_LIMIT);
  localparam logic [W-1:0] LIM    = W'(ISO_LIMIT);
  localparam logic [W-1:0] LIM_M1 = W'(ISO_LIMIT - 1);

  logic [W-1:0] iso_cnt_q;
  logic         over_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iso_cnt_q <= '0;
      over_q    <= 1'b0;
    end else begin
      if (fire_i)                             iso_cnt_q <= '0;
      else if (iso_active_i && iso_cnt_q != LIM) iso_cnt_q <= iso_cnt_q + 1'b1;

      if (bus_reset_i)                              over_q <= 1'b0;
      else if (iso_active_i && iso_cnt_q == LIM_M1) over_q <= 1'b1;
    end
  end

  assign over_alloc_o = over_q;
endmodule

// File: rtl/icc_fairness.sv
module icc_fairness (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_reset_i,
  input  logic rst_gap_i,
  input  logic arb_won_i,
  input  logic iso_req_i,
  input  logic async_req_i,
  output logic arb_enable_o,
  output logic arb_req_o
);
  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          en_q <= 1'b1;
    else if (bus_reset_i) en_q <= 1'b1;
    else if (arb_won_i)   en_q <= 1'b0;
    else if (rst_gap_i)   en_q <= 1'b1;
  end

  assign arb_enable_o = en_q;
  // isochronous requests bypass the fairness flag
  assign arb_req_o    = iso_req_i | (async_req_i & en_q);
endmodule

// File: rtl/iso_cycle_ctrl.sv
module iso_cycle_ctrl
  import iso_cycle_pkg::*;
#(
  parameter int CYCLE_TICKS = 6144,
  parameter int SUBACT_GAP  = 49,
  parameter int ARB_RST_GAP = 98,
  parameter int ISO_LIMIT   = 4915,
  parameter int DELAY_W     = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_reset_i,
  input  logic               bus_idle_i,
  input  logic               is_root_i,
  input  logic               iso_active_i,
  input  logic               iso_req_i,
  input  logic               async_req_i,
  input  logic               arb_won_i,
  output logic               cycle_start_o,
  output logic [DELAY_W-1:0] start_delay_o,
  output logic               subact_gap_o,
  output logic               arb_rst_gap_o,
  output logic               arb_enable_o,
  output logic               arb_req_o,
  output logic               over_alloc_o
);
  gap_info_t gap;
  logic      fire;
  logic      over;

  icc_gap_classifier #(
    .SUBACT_GAP (SUBACT_GAP),
    .ARB_RST_GAP(ARB_RST_GAP)
  ) u_gap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bus_idle_i(bus_idle_i),
    .gap_o     (gap)
  );

  icc_cycle_timer #(
    .CYCLE_TICKS(CYCLE_TICKS),
    .DELAY_W    (DELAY_W)
  ) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .is_root_i    (is_root_i),
    .gap_ok_i     (gap.gap_ok),
    .inhibit_i    (over),
    .fire_o       (fire),
    .cycle_start_o(cycle_start_o),
    .start_delay_o(start_delay_o)
  );

  icc_iso_watchdog #(
    .ISO_LIMIT(ISO_LIMIT)
  ) u_wdog (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_reset_i (bus_reset_i),
    .iso_active_i(iso_active_i),
    .fire_i      (fire),
    .over_alloc_o(over)
  );

  icc_fairness u_fair (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_reset_i (bus_reset_i),
    .rst_gap_i   (gap.rst_gap),
    .arb_won_i   (arb_won_i),
    .iso_req_i   (iso_req_i),
    .async_req_i (async_req_i),
    .arb_enable_o(arb_enable_o),
    .arb_req_o   (arb_req_o)
  );

  assign subact_gap_o  = gap.sub_gap;
  assign arb_rst_gap_o = gap.rst_gap;
  assign over_alloc_o  = over;
endmodule

// File: rtl/iso_cycle_ctrl_chk.sv
module iso_cycle_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bus_reset_i,
  input logic bus_idle_i,
  input logic is_root_i,
  input logic iso_req_i,
  input logic arb_won_i,
  input logic cycle_start_o,
  input logic subact_gap_o,
  input logic arb_rst_gap_o,
  input logic arb_enable_o,
  input logic arb_req_o,
  input logic over_alloc_o
);
  // R2
  cs_root_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_start_o |-> $past(is_root_i));
  // R9
  cs_not_over_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_start_o |-> !$past(over_alloc_o));
  // R3
  cs_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_start_o |=> !cycle_start_o);
  // R5
  sub_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    subact_gap_o |=> !subact_gap_o);
  // R6
  rst_gap_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_rst_gap_o |-> $past(bus_idle_i));
  // R9
  over_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    over_alloc_o && !bus_reset_i |=> over_alloc_o);
  // R7
  won_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_won_i && !bus_reset_i |=> !arb_enable_o);
  // R10
  bres_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> arb_enable_o && !over_alloc_o);
  // R8
  iso_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iso_req_i |-> arb_req_o);
endmodule

bind iso_cycle_ctrl iso_cycle_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_reset_i  (bus_reset_i),
  .bus_idle_i   (bus_idle_i),
  .is_root_i    (is_root_i),
  .iso_req_i    (iso_req_i),
  .arb_won_i    (arb_won_i),
  .cycle_start_o(cycle_start_o),
  .subact_gap_o (subact_gap_o),
  .arb_rst_gap_o(arb_rst_gap_o),
  .arb_enable_o (arb_enable_o),
  .arb_req_o    (arb_req_o),
  .over_alloc_o (over_alloc_o)
);

// File: tb/sim_iso_cycle_ctrl.sv
module sim_iso_cycle_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CYC = 40;
  localparam int SG  = 3;
  localparam int RG  = 8;
  localparam int IL  = 20;
  localparam int DW  = 16;
  localparam int DMAX = (1 << DW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bres = 0, idle = 1, root = 0, iso_act = 0, iso_req = 0, async_req = 0, won = 0;

  logic          cs, sg, rg, en, req, over;
  logic [DW-1:0] sd;

  int checks = 0, failures = 0;
  bit done = 0;

  // reference state, derived from the requirements
  int  m_cyc, m_dly, m_idle, m_iso, m_sd;
  bit  m_pend, m_over, m_en, m_cs, m_sg, m_rg;

  always #(CLK_PERIOD/2) clk = ~clk;

  iso_cycle_ctrl #(
    .CYCLE_TICKS(CYC), .SUBACT_GAP(SG), .ARB_RST_GAP(RG), .ISO_LIMIT(IL), .DELAY_W(DW)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_reset_i(bres), .bus_idle_i(idle),
    .is_root_i(root), .iso_active_i(iso_act), .iso_req_i(iso_req),
    .async_req_i(async_req), .arb_won_i(won), .cycle_start_o(cs),
    .start_delay_o(sd), .subact_gap_o(sg), .arb_rst_gap_o(rg),
    .arb_enable_o(en), .arb_req_o(req), .over_alloc_o(over)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cyc = 0; m_dly = 0; m_idle = 0; m_iso = 0; m_sd = 0;
      m_pend = 0; m_over = 0; m_en = 1; m_cs = 0; m_sg = 0; m_rg = 0;
    end else begin
      bit fire, tick;
      fire = m_pend && root && (m_idle >= SG) && !m_over;
      tick = root && (m_cyc == CYC - 1);
      if (bres) m_en = 1; else if (won) m_en = 0; else if (m_rg) m_en = 1;
      if (bres) m_over = 0; else if (iso_act && m_iso == IL - 1) m_over = 1;
      if (fire) m_iso = 0; else if (iso_act && m_iso != IL) m_iso++;
      m_cs = fire;
      if (fire) m_sd = m_dly;
      if (tick && !m_pend) m_dly = 0; else if (m_pend && m_dly != DMAX) m_dly++;
      if (!root || fire) m_pend = 0; else if (tick) m_pend = 1;
      if (!root || tick) m_cyc = 0; else m_cyc++;
      m_sg = idle && (m_idle == SG - 1);
      m_rg = idle && (m_idle == RG - 1);
      if (!idle) m_idle = 0; else if (m_idle != RG) m_idle++;
    end
  end

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", r, act, exp);
    end
  endtask

  task automatic cmp_regs();
    chk("R2 R3 cycle_start", int'(cs), int'(m_cs));
    chk("R4 start_delay", int'(sd), m_sd);
    chk("R5 subact_gap", int'(sg), int'(m_sg));
    chk("R6 arb_rst_gap", int'(rg), int'(m_rg));
    chk("R7 R10 arb_enable", int'(en), int'(m_en));
    chk("R9 R10 over_alloc", int'(over), int'(m_over));
  endtask

  // one clock: check registered outputs, drive new inputs, check the comb path
  task automatic step(bit i_idle, bit i_root, bit i_iso, bit i_ireq, bit i_areq, bit i_won, bit i_bres);
    @(negedge clk);
    cmp_regs();
    idle = i_idle; root = i_root; iso_act = i_iso; iso_req = i_ireq;
    async_req = i_areq; won = i_won; bres = i_bres;
    #1;
    chk("R8 arb_req", int'(req), int'(i_ireq | (i_areq & m_en)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R3 watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seg_left, seg_idle, iso_seg;
    void'($urandom(32'd1394));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cycle_start", int'(cs), 0);
    chk("R1 start_delay", int'(sd), 0);
    chk("R1 subact_gap", int'(sg), 0);
    chk("R1 arb_rst_gap", int'(rg), 0);
    chk("R1 arb_enable", int'(en), 1);
    chk("R1 over_alloc", int'(over), 0);
    root = 1;
    rst_n = 1;

    // R2 R3: idle bus, regular starts
    repeat (130) step(1, 1, 0, 0, 0, 0, 0);
    // R4: busy past two ticks, merged and delayed start
    repeat (100) step(0, 1, 0, 0, 1, 0, 0);
    repeat (20)  step(1, 1, 0, 0, 1, 0, 0);
    // R9: isochronous overrun suppresses starts
    repeat (25) step(0, 1, 1, 1, 0, 0, 0);
    repeat (90) step(1, 1, 0, 0, 0, 0, 0);
    // R10: bus reset releases
    step(1, 1, 0, 0, 0, 0, 1);
    repeat (60) step(1, 1, 0, 0, 0, 0, 0);
    // R7: win on the edge that would set the enable flag
    step(0, 1, 0, 0, 1, 0, 0);
    repeat (8) step(1, 1, 0, 0, 1, 0, 0);
    step(1, 1, 0, 0, 1, 1, 0);
    repeat (3) step(0, 1, 0, 0, 1, 0, 0);
    // R10: bus reset beats a simultaneous win
    step(0, 1, 0, 0, 1, 1, 1);
    repeat (3) step(0, 1, 0, 0, 1, 0, 0);
    // R2: root drops while pending
    repeat (35) step(0, 1, 0, 0, 0, 0, 0);
    repeat (30) step(1, 0, 0, 0, 0, 0, 0);
    repeat (60) step(1, 1, 0, 0, 0, 0, 0);

    // constrained random
    seg_left = 0; seg_idle = 0; iso_seg = 0;
    for (int n = 0; n < 9000; n++) begin
      bit r_root;
      if (seg_left == 0) begin
        seg_idle = !seg_idle;
        seg_left = seg_idle ? 1 + int'($urandom_range(14)) : 1 + int'($urandom_range(11));
        iso_seg  = (!seg_idle) && ($urandom_range(3) == 0);
      end
      seg_left--;
      r_root = !((n % 1500) >= 1400);
      step(seg_idle, r_root, iso_seg, $urandom_range(5) == 0, $urandom_range(1) == 1,
           $urandom_range(29) == 0, $urandom_range(399) == 0);
    end

    @(negedge clk);
    cmp_regs();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule